// File: doc/BRIEF.md
# Clock Not-Recently-Used Victim Selector

This block picks which page frame to evict when a new page has to come into memory. Each frame has one flag. The flag goes high whenever the frame is used, so it records recent use. When a replacement is requested, a circular hand sweeps the frames one per clock. Each frame it passes with a raised flag has that flag cleared, which gives the frame a second chance. The sweep stops at the first frame whose flag is already low, and that frame becomes the victim.

The hand is persistent. It rests on the most recent victim, and the next sweep starts one frame past it. Memory-management logic drives a strobe with a frame index on every page access. It raises a request when a frame is needed and waits for a one-cycle done pulse carrying the victim index. Page contents and the translation table live elsewhere.

Top module: `clock_nru_selector`

## Requirements
- R1: After reset all use flags are clear, the hand rests on frame 0, `sel_done` and `scanning` are low, and `sel_frame` is 0.
- R2: A strobe on `touch_valid` with index `touch_frame` raises that frame's flag, so a later sweep passes over it.
- R3: A sweep begins at the frame after the hand, examines one frame per clock and wraps from the last frame to frame 0.
- R4: Every frame that a sweep passes over because its flag is high has its flag cleared, so a following sweep can select it.
- R5: The sweep selects the first examined frame whose flag is low. `sel_done` pulses high for exactly one cycle, and `sel_frame` carries the victim and holds its value between pulses.
- R6: If every flag is high, the sweep clears all of them and selects its starting frame after NUM_FRAMES+1 examinations. No sweep lasts longer than that.
- R7: After a selection the hand rests on the victim.
- R8: A strobe that targets the frame being examined in the same cycle leaves that frame's flag high: setting wins over clearing.
- R9: A request raised while a sweep is in progress is ignored.
- R10: `scanning` is high from the cycle after an accepted request until the selection cycle, and is never high together with `sel_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| touch_valid | input | 1 | Frame-use strobe |
| touch_frame | input | IDX_W | Index of the frame being used |
| evict_req | input | 1 | Request for a victim; accepted only while idle |
| sel_frame | output | IDX_W | Index of the most recent victim |
| sel_done | output | 1 | One-cycle pulse when a victim is chosen |
| scanning | output | 1 | Sweep in progress |

## Verification
The bound checker watches these on every cycle:
- the done pulse is one cycle wide and never coincides with `scanning`;
- a sweep starts only after a request;
- `sel_frame` holds its value between pulses;
- no sweep runs longer than NUM_FRAMES+1 cycles.

Only the bench's scenarios can show which frame is chosen: that passed-over flags really end up cleared, that the hand resumes past the last victim, and that a strobe on the examined frame beats the clear. The bench's behavioural model predicts every output on every clock.

// File: rtl/clock_nru_pkg.sv
package clock_nru_pkg;
  typedef enum logic {HAND_IDLE = 1'b0, HAND_SWEEP = 1'b1} hand_state_t;
endpackage

// File: rtl/use_flag_bank.sv
module use_flag_bank #(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  logic [NUM_FRAMES-1:0] flags;

  // One flop per frame; a set on the same frame overrides a clear.
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[g] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(g))
        flags[g] <= 1'b1;
      else if (clr_en && clr_idx == IDX_W'(g))
        flags[g] <= 1'b0;
    end
  end

  assign rd_bit = flags[rd_idx];
endmodule

// File: rtl/hand_sweeper.sv
module hand_sweeper
  import clock_nru_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W      = $clog2(NUM_FRAMES),
  parameter int CNT_W      = $clog2(NUM_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evict_req,
  input  logic             cur_bit,
  output logic [IDX_W-1:0] cur_idx,
  output logic             clr_en,
  output logic [IDX_W-1:0] sel_frame,
  output logic             sel_done,
  output logic             scanning
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_FRAMES);

  hand_state_t      state;
  logic [IDX_W-1:0] hand;
  logic [IDX_W-1:0] probe;
  logic [CNT_W-1:0] passed;
  logic             hit;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  assign hit     = (state == HAND_SWEEP) && (!cur_bit || passed == FULL);
  assign clr_en  = (state == HAND_SWEEP) && !hit;
  assign cur_idx = probe;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= HAND_IDLE;
      hand      <= '0;
      probe     <= '0;
      passed    <= '0;
      sel_frame <= '0;
      sel_done  <= 1'b0;
    end else begin
      sel_done <= 1'b0;
      case (state)
        HAND_IDLE: if (evict_req) begin
          state  <= HAND_SWEEP;
          probe  <= step(hand);
          passed <= '0;
        end
        HAND_SWEEP: if (hit) begin
          state     <= HAND_IDLE;
          hand      <= probe;
          sel_frame <= probe;
          sel_done  <= 1'b1;
        end else begin
          probe  <= step(probe);
          passed <= passed + 1'b1;
        end
        default: state <= HAND_IDLE;
      endcase
    end
  end

  assign scanning = (state == HAND_SWEEP);
endmodule

// File: rtl/clock_nru_selector.sv
module clock_nru_selector #(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_valid,
  input  logic [IDX_W-1:0] touch_frame,
  input  logic             evict_req,
  output logic [IDX_W-1:0] sel_frame,
  output logic             sel_done,
  output logic             scanning
);
  logic [IDX_W-1:0] cur_idx;
  logic             cur_bit;
  logic             clr_en;

  use_flag_bank #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst),
    .set_en(touch_valid), .set_idx(touch_frame),
    .clr_en(clr_en), .clr_idx(cur_idx),
    .rd_idx(cur_idx), .rd_bit(cur_bit)
  );

  hand_sweeper #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_hand (
    .clk(clk), .rst(rst), .evict_req(evict_req),
    .cur_bit(cur_bit), .cur_idx(cur_idx), .clr_en(clr_en),
    .sel_frame(sel_frame), .sel_done(sel_done), .scanning(scanning)
  );
endmodule

// File: rtl/clock_nru_checker.sv
module clock_nru_checker #(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input logic             clk,
  input logic             rst,
  input logic             evict_req,
  input logic [IDX_W-1:0] sel_frame,
  input logic             sel_done,
  input logic             scanning
);
  localparam int RUN_W = $clog2(NUM_FRAMES + 3);
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || !scanning) run_len <= '0;
    else if (run_len != '1) run_len <= run_len + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!sel_done && !scanning));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) sel_done |=> !sel_done);
  // R5
  victim_hold_chk: assert property (@(posedge clk) disable iff (rst) !sel_done |-> $stable(sel_frame));
  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst) sel_done |-> !scanning);
  // R10
  sweep_start_chk: assert property (@(posedge clk) disable iff (rst) $rose(scanning) |-> $past(evict_req));
  // R6
  sweep_bound_chk: assert property (@(posedge clk) disable iff (rst) scanning |-> run_len <= RUN_W'(NUM_FRAMES + 1));
endmodule

bind clock_nru_selector clock_nru_checker #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .evict_req(evict_req),
  .sel_frame(sel_frame), .sel_done(sel_done), .scanning(scanning)
);

// File: tb/sim_clock_nru_selector.sv
`timescale 1ns/1ps
module sim_clock_nru_selector;
  localparam int N = 8;
  localparam int W = $clog2(N);

  logic clk = 0, rst = 1, touch_valid = 0, evict_req = 0;
  logic [W-1:0] touch_frame = '0;
  logic [W-1:0] sel_frame;
  logic sel_done, scanning;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  clock_nru_selector #(.NUM_FRAMES(N)) u0 (
    .clk(clk), .rst(rst), .touch_valid(touch_valid), .touch_frame(touch_frame),
    .evict_req(evict_req), .sel_frame(sel_frame), .sel_done(sel_done), .scanning(scanning)
  );

  // Behavioural reference model
  int m_flag [N];
  int m_hand, m_probe, m_passed, m_vic;
  bit m_sweep, m_done;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_flag[i]) m_flag[i] = 0;
      m_hand = 0; m_probe = 0; m_passed = 0; m_vic = 0; m_sweep = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (!m_sweep) begin
        if (evict_req) begin m_sweep = 1; m_probe = (m_hand + 1) % N; m_passed = 0; end
      end else if (m_flag[m_probe] == 0 || m_passed == N) begin
        m_vic = m_probe; m_hand = m_probe; m_done = 1; m_sweep = 0;
      end else begin
        m_flag[m_probe] = 0; m_passed++; m_probe = (m_probe + 1) % N;
      end
      if (touch_valid) m_flag[touch_frame] = 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    check("R5 done vs model", int'(sel_done), int'(m_done));
    check("R5 victim vs model", int'(sel_frame), m_vic);
    check("R10 scanning vs model", int'(scanning), int'(m_sweep));
  end

  task automatic touch(input int f);
    touch_valid = 1; touch_frame = W'(f);
    @(negedge clk);
    touch_valid = 0;
  endtask

  // returns victim and cycles = examinations + 1
  task automatic evict(output int v, output int cyc);
    evict_req = 1;
    @(negedge clk);
    evict_req = 0;
    cyc = 1;
    while (sel_done !== 1'b1 && cyc < 200) begin @(negedge clk); cyc++; end
    if (cyc >= 200) check("watchdog", 0, 1);
    v = int'(sel_frame);
  endtask

  int v, c, pulses;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check("R1 done low", int'(sel_done), 0);
    check("R1 scanning low", int'(scanning), 0);
    check("R1 victim zero", int'(sel_frame), 0);
    // R3: first sweep starts after frame 0
    evict(v, c);
    check("R3 first victim", v, 1);
    check("R5 single-exam latency", c, 2);
    // R2 R4 R7: frames 2,3 used, skipped and cleared
    touch(2); touch(3);
    evict(v, c);
    check("R2 used frames skipped", v, 4);
    check("R4 three examinations", c, 4);
    evict(v, c);
    check("R7 resumes after victim", v, 5);
    // R6: all flags set
    for (int i = 0; i < N; i++) touch(i);
    evict(v, c);
    check("R6 all-set selects start", v, 6);
    check("R6 bound examinations", c, N + 2);
    evict(v, c);
    check("R4 flags cleared by sweep", v, 7);
    // R8: touch frame 0 while it is examined
    touch(0); touch(1);
    evict_req = 1;
    @(negedge clk);
    evict_req = 0; touch_valid = 1; touch_frame = '0;
    @(negedge clk);
    touch_valid = 0;
    c = 2;
    while (sel_done !== 1'b1 && c < 200) begin @(negedge clk); c++; end
    check("R8 sweep result", int'(sel_frame), 2);
    for (int i = 3; i < N; i++) begin evict(v, c); check("R3 wrap walk", v, i); end
    evict(v, c);
    check("R8 set won over clear", v, 1);
    // R9: request during sweep ignored
    for (int i = 0; i < N; i++) touch(i);
    evict_req = 1;
    @(negedge clk);
    evict_req = 0;
    repeat (2) @(negedge clk);
    evict_req = 1;
    @(negedge clk);
    evict_req = 0;
    pulses = 0;
    for (int i = 0; i < 3 * N; i++) begin
      if (sel_done) pulses++;
      @(negedge clk);
    end
    check("R9 single selection", pulses, 1);
    check("R9 idle afterwards", int'(scanning), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule